// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static RAM whose inputs and outputs are both registered. The full-size part has an 18-bit address and a 36-bit word. Here the address width is a parameter, so that the depth can be cut down for simulation. The word is four 9-bit byte lanes, and each lane has its own active-low write enable. Commands are an active-low select and an active-low write enable, sampled on the rising clock. A sampled read launches its word from an output register one clock later. The word is therefore visible on the outputs after the second rising edge, counting the edge that sampled the read.

Writes are late. The data for a write arrives on the edge after its address and control. It is parked in a one-entry pending-write buffer together with its address and lane mask. It reaches the array only at the edge that captures the data of the next write. An address comparator sits on the read path. When a read hits the pending address, the buffered lanes replace the lanes read from the array, so a read issued right after a write returns the new data.

The three-state bus is modelled by a `drive_en` output. An asynchronous active-low output enable can force it off at any time. A registered sleep input overrides everything else: while it is in effect, nothing is driven and commands are dropped. A write sampled with all four lane enables high is an abort. The system must leave one idle cycle between a read and a following write, so that the bus can turn around.

Top module: `lw_sync_sram`

## Requirements
- R1: While reset is high, and in the first cycle after it, `drive_en` is 0.
- R2: A read (`cs_n`=0, `we_n`=1) sampled at edge N puts the addressed word on `rdata` after edge N+1. `drive_en` is then 1 if `oe_n` is 0 and sleep is not in effect.
- R3: A cycle sampled with `cs_n`=1 is a deselect. It changes no stored word, and it does not set `drive_en` after the following edge.
- R4: A write (`cs_n`=0, `we_n`=0) updates only lane k, bits [9k+8:9k], for each k whose `be_n[k]` is 0. The other lanes keep their old contents.
- R5: A write sampled with `be_n`=4'hF is an abort. It changes no stored word and no pending data, and it drives nothing.
- R6: Write data is taken from `wdata` at the edge after the write's address. `wdata` at any other edge has no effect.
- R7: A read sampled at the edge that captures a write's data, or at any later edge, returns that write's lanes merged over the older contents, whether or not the write has reached the array yet.
- R8: `oe_n`=1 forces `drive_en` to 0 in the same cycle, whatever the read state.
- R9: `sleep` is registered. A command sampled at an edge where the registered sleep flag is set is ignored, and `drive_en` is 0 while the flag is set. The first edge that sees `sleep` high still accepts a command. The first edge that sees it low again does not.
- R10: The block never drives the bus during the cycle in which a write's data is captured, provided one idle cycle separates a read from the following write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, sampled with the command |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write enable |
| be_n | input | 4 | Active-low lane write enables; bit k covers data bits [9k+8:9k] |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Active-high sleep request, registered |
| wdata | input | 36 | Write data, sampled one edge after its write command |
| rdata | output | 36 | Output register contents |
| drive_en | output | 1 | High when the model would drive the data bus |

## Verification
The checker assumes the system respects the turnaround rule. An accepted read is never followed at the very next edge by an accepted write, and a property flags any stimulus that breaks this. The drive-timing properties also assume that `oe_n` and `sleep` change only between edges. The bench inserts an idle cycle whenever a write would follow an accepted read, and it changes every input on the falling edge. It sweeps all sixteen lane masks against a reference array. Reads are issued both immediately after writes and after the writes have been committed.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e   op;
        lane_t mask;
    } cmd_t;

    // Classify one sampled cycle; an abort or a dropped cycle becomes OP_NONE.
    function automatic op_e decode_op(logic sel_n, logic wr_n, lane_t ben, logic asleep);
        op_e r;
        if (asleep || sel_n)
            r = OP_NONE;
        else if (wr_n)
            r = OP_READ;
        else if (&ben)
            r = OP_NONE;
        else
            r = OP_WRITE;
        return r;
    endfunction

    // Replace the lanes selected by take with the lanes of over.
    function automatic word_t lane_merge(word_t base, word_t over, lane_t take);
        word_t r;
        r = base;
        for (int l = 0; l < LANES; l++) begin
            if (take[l])
                r[l*LANE_W +: LANE_W] = over[l*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/lw_sram_cmd_reg.sv
module lw_sram_cmd_reg
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  lane_t             be_n,
    input  logic              sleep,
    output cmd_t              cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              sleep_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '{op: OP_NONE, mask: '0};
            addr_q  <= '0;
            sleep_q <= 1'b0;
        end else begin
            cmd_q.op   <= decode_op(cs_n, we_n, be_n, sleep_q);
            cmd_q.mask <= ~be_n;
            addr_q     <= addr;
            sleep_q    <= sleep;
        end
    end

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  word_t             wdata,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output lane_t             pend_mask,
    output word_t             pend_data,
    output logic              commit_en
);

    logic take_data;

    assign take_data = (cmd_q.op == OP_WRITE);
    // The older pending write leaves for the array as the new data arrives.
    assign commit_en = take_data && pend_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_mask  <= '0;
            pend_data  <= '0;
        end else if (take_data) begin
            pend_valid <= 1'b1;
            pend_addr  <= addr_q;
            pend_mask  <= cmd_q.mask;
            pend_data  <= wdata;
        end
    end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  lane_t             wr_mask,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l])
                cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
        end

        assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/lw_sram_out.sv
module lw_sram_out
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  word_t             arr_data,
    input  logic              pend_valid,
    input  logic [ADDR_W-1:0] pend_addr,
    input  lane_t             pend_mask,
    input  word_t             pend_data,
    input  logic              oe_n,
    input  logic              sleep_q,
    output word_t             rdata,
    output logic              drive_en
);

    logic  hit;
    word_t read_word;
    logic  out_valid;

    assign hit       = pend_valid && (pend_addr == addr_q);
    assign read_word = hit ? lane_merge(arr_data, pend_data, pend_mask) : arr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            rdata     <= '0;
        end else begin
            out_valid <= (cmd_q.op == OP_READ);
            if (cmd_q.op == OP_READ)
                rdata <= read_word;
        end
    end

    assign drive_en = out_valid && !oe_n && !sleep_q;

endmodule

// File: rtl/lw_sync_sram.sv
module lw_sync_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [3:0]        be_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [35:0]       wdata,
    output logic [35:0]       rdata,
    output logic              drive_en
);

    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sleep_q;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    lane_t             pend_mask;
    word_t             pend_data;
    logic              commit_en;
    word_t             arr_data;

    lw_sram_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .be_n    (be_n),
        .sleep   (sleep),
        .cmd_q   (cmd_q),
        .addr_q  (addr_q),
        .sleep_q (sleep_q)
    );

    lw_sram_wbuf #(.ADDR_W(ADDR_W)) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .cmd_q      (cmd_q),
        .addr_q     (addr_q),
        .wdata      (wdata),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_mask  (pend_mask),
        .pend_data  (pend_data),
        .commit_en  (commit_en)
    );

    lw_sram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_addr (pend_addr),
        .wr_mask (pend_mask),
        .wr_data (pend_data),
        .rd_addr (addr_q),
        .rd_data (arr_data)
    );

    lw_sram_out #(.ADDR_W(ADDR_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .cmd_q      (cmd_q),
        .addr_q     (addr_q),
        .arr_data   (arr_data),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_mask  (pend_mask),
        .pend_data  (pend_data),
        .oe_n       (oe_n),
        .sleep_q    (sleep_q),
        .rdata      (rdata),
        .drive_en   (drive_en)
    );

endmodule

// File: rtl/lw_sync_sram_chk.sv
module lw_sync_sram_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       we_n,
    input logic [3:0] be_n,
    input logic       oe_n,
    input logic       drive_en,
    input logic       sleep_q,
    input logic       commit_en
);

    // R1: nothing driven in the cycle right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !drive_en);

    // R2: an accepted read drives two edges later unless gated
    a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && !sleep_q) |=> ##1 (drive_en || oe_n || sleep_q));

    // R3: a deselect leaves the bus undriven two edges later
    a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ##1 !drive_en);

    // R5: an abort never leads to an array commit
    a_r5_abort_no_commit: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n && (be_n == 4'hF) && !sleep_q) |=> !commit_en);

    // R9: a command dropped under sleep never drives the bus
    a_r9_sleep_drops: assert property (@(posedge clk) disable iff (rst)
        sleep_q |=> ##1 !drive_en);

    // R10: input rule, an accepted read is not followed at once by an accepted write
    a_r10_turnaround: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && !sleep_q) |=> !(!cs_n && !we_n && !sleep_q));

endmodule

bind lw_sync_sram lw_sync_sram_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .be_n      (be_n),
    .oe_n      (oe_n),
    .drive_en  (drive_en),
    .sleep_q   (sleep_q),
    .commit_en (commit_en)
);

// File: tb/lw_sync_sram_bench.sv
module lw_sync_sram_bench;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic [3:0]    be_n = 4'hF;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [35:0]   wdata = '0;
    logic [35:0]   rdata;
    logic          drive_en;

    always #5 clk = ~clk;

    lw_sync_sram #(.ADDR_W(AW)) u_lw_sync_sram (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .be_n     (be_n),
        .oe_n     (oe_n),
        .sleep    (sleep),
        .wdata    (wdata),
        .rdata    (rdata),
        .drive_en (drive_en)
    );

    int          nerr = 0;
    int          nchk = 0;
    bit          done = 1'b0;
    string       cur_tag = "R1";

    logic [35:0] ref_mem [DEPTH];
    bit          pw_valid = 1'b0;
    int          pw_addr = 0;
    logic [3:0]  pw_take = '0;
    logic [35:0] hold_wd = '0;
    bit          prev_rd = 1'b0;
    logic [35:0] prev_exp = '0;
    bit          sleep_flag = 1'b0;
    bit          last_acc_read = 1'b0;
    bit          oe_set = 1'b0;
    bit          sleep_set = 1'b0;
    int          cyc = 0;

    function automatic logic [35:0] pat(int a, int s);
        logic [35:0] r;
        r = ({28'd0, 8'(a)} * 36'd40503) ^ ({28'd0, 8'(s)} << 20) ^ 36'h9A5C33C5A;
        return r;
    endfunction

    task automatic check(bit ok, logic [35:0] act, logic [35:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", cur_tag, act, exp, cyc);
        end
    endtask

    // One clock: drive a command at the falling edge, then model and check.
    task automatic step(logic c, logic w, logic [3:0] b, int a, logic [35:0] d);
        bit exp_drive;
        @(negedge clk);
        cs_n  = c;
        we_n  = w;
        be_n  = b;
        addr  = AW'(a);
        oe_n  = oe_set;
        sleep = sleep_set;
        wdata = pw_valid ? hold_wd : (~hold_wd ^ 36'(cyc * 7919));
        @(posedge clk);
        #1;
        cyc++;
        if (pw_valid) begin
            for (int l = 0; l < 4; l++)
                if (pw_take[l]) ref_mem[pw_addr][l*9 +: 9] = wdata[l*9 +: 9];
            pw_valid = 1'b0;
        end
        exp_drive = prev_rd && !oe_set && !sleep_set;
        check(drive_en == exp_drive, 36'(drive_en), 36'(exp_drive));
        if (prev_rd)
            check(rdata == prev_exp, rdata, prev_exp);
        prev_rd       = 1'b0;
        last_acc_read = 1'b0;
        if (!sleep_flag && !c) begin
            if (w) begin
                prev_rd       = 1'b1;
                prev_exp      = ref_mem[a];
                last_acc_read = 1'b1;
            end else if (b != 4'hF) begin
                pw_valid = 1'b1;
                pw_addr  = a;
                pw_take  = ~b;
                hold_wd  = d;
            end
        end
        sleep_flag = sleep_set;
    endtask

    task automatic idle();
        step(1'b1, 1'b1, 4'hF, 0, '0);
    endtask

    task automatic rd(int a);
        step(1'b0, 1'b1, 4'hF, a, '0);
    endtask

    task automatic wr(int a, logic [3:0] b, logic [35:0] d);
        if (last_acc_read) idle();
        step(1'b0, 1'b0, b, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        repeat (3) @(posedge clk);
        #1;
        check(drive_en == 1'b0, 36'(drive_en), 36'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(drive_en == 1'b0, 36'(drive_en), 36'd0);

        // fill with back-to-back full writes
        cur_tag = "R6";
        for (int a = 0; a < DEPTH; a++) wr(a, 4'h0, pat(a, 1));
        idle();
        for (int a = 0; a < DEPTH; a++) rd(a);
        idle();

        // R2: reads interleaved with deselects
        cur_tag = "R2";
        for (int a = 0; a < DEPTH; a += 3) begin
            rd(a);
            idle();
        end

        // R7 and R5: every lane mask, read issued right after the write
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 2; k++) begin
                int a;
                a = (k == 0) ? 3 : 40;
                cur_tag = (m == 15) ? "R5" : "R7";
                wr(a, 4'(m), pat(a, m + 7));
                rd(a);
            end
        end
        idle();
        idle();

        // R4: read back everything after commits
        cur_tag = "R4";
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, 4'(a % 16), pat(a, 50));
            wr((a + 17) % DEPTH, 4'((a * 5) % 16), pat(a, 60));
        end
        idle();
        for (int a = 0; a < DEPTH; a++) rd(a);
        idle();

        // R3: deselected writes change nothing
        cur_tag = "R3";
        for (int a = 0; a < 8; a++) step(1'b1, 1'b0, 4'h0, a, pat(a, 99));
        for (int a = 0; a < 8; a++) rd(a);
        idle();

        // R8: output enable gating
        cur_tag = "R8";
        for (int a = 8; a < 16; a++) begin
            oe_set = (a % 2 == 0);
            rd(a);
        end
        oe_set = 1'b0;
        idle();
        oe_set = 1'b1;
        idle();
        oe_set = 1'b0;

        // R9: sleep entry and exit
        cur_tag = "R9";
        rd(20);
        sleep_set = 1'b1;
        rd(21);
        rd(22);
        wr(23, 4'h0, pat(23, 200));
        wr(24, 4'h0, pat(24, 201));
        idle();
        sleep_set = 1'b0;
        wr(25, 4'h0, pat(25, 202));
        idle();
        for (int a = 20; a < 27; a++) rd(a);
        idle();
        wr(26, 4'h3, pat(26, 203));
        sleep_set = 1'b1;
        rd(26);
        idle();
        sleep_set = 1'b0;
        idle();
        idle();
        rd(26);
        idle();

        // R10: read, dead cycle, write, read
        cur_tag = "R10";
        for (int a = 30; a < 40; a++) begin
            rd(a);
            wr(a + 1, 4'((a * 3) % 15), pat(a, 300));
            rd(a + 1);
        end
        idle();
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule